// File: doc/BRIEF.md
# Peripheral Command Packet Responder

This block is the command end of a small system controller. A transfer engine delivers a whole received packet to it as a parallel byte buffer with a length and a one-cycle valid strobe. The block decodes the packet type and command and returns a finished reply buffer with its own length and one-cycle valid strobe, ready to be shifted back to the host. It also keeps a 32-bit seconds count for a real-time clock, advanced by a one-second tick, and runs an auto-poll timer that asks an external peripheral bus agent for data at a fixed rate.

Packets of the bus type are not answered locally. Their payload goes to an external hook as a request, and the reply is built from the status and data the hook returns. The same hook serves the periodic poll. Power-down and restart commands are acknowledged first and then raise a single-cycle system request pulse.

Top module: `cmd_responder`

## Requirements
- R1: After reset no reply, hook request or system request is raised, the seconds count is 0 and auto-poll is off.
- R2: Byte 0 of a packet is its type: 0x00 bus, 0x01 device, 0x02 error. A packet of any other type gets the 2-byte error reply {0x02, type}. A device packet shorter than 2 bytes gets {0x02, 0xFF}. An unknown command code in byte 1 gets {0x02, code}.
- R3: Command 0x03 returns the 7-byte reply {0x01, 0x00, 0x03, s[31:24], s[23:16], s[15:8], s[7:0]}, where s is the seconds count (seconds since the start of 1904).
- R4: The seconds count rises by one, wrapping modulo 2^32, in each cycle where tick_1s is high. Command 0x09 with at least 6 bytes loads bytes 2 to 5 (byte 2 most significant) and replies {0x01, 0x00}. A load beats a tick in the same cycle. A shorter 0x09 packet gets the error reply {0x02, 0x09} and leaves the count alone.
- R5: Commands 0x13, 0x14, 0x19 and 0x21 do nothing and are answered {0x01, 0x00}.
- R6: Command 0x0A replies {0x01, 0x00}, and shutdown_req pulses for one cycle in the cycle right after the reply. Command 0x11 does the same with reset_req. No other command raises either request.
- R7: For device and error packets, rsp_valid is a one-cycle pulse in the cycle after pkt_valid is sampled. A reply never coincides with a hook request, and its length is always between 2 and the reply buffer size.
- R8: A bus-type packet of length L raises hook_req for one cycle in the next cycle, with hook_poll=0, hook_len=L-1 and hook_data holding packet bytes 1 onward. When hook_done is sampled, the next cycle carries the reply {0x00, hook_status, data...} of length 2+hook_rlen.
- R9: Command 0x01 turns auto-poll on when byte 2 is nonzero, and off when byte 2 is zero or missing. It replies {0x01, 0x00}. While auto-poll is on, a hook request with hook_poll=1 and hook_len=0 is issued once every POLL_DIV cycles.
- R10: A poll answered with hook_rlen>0 produces the reply {0x00, 0x40, data...} of length 2+hook_rlen. A poll answered with hook_rlen=0 produces no reply.
- R11: A hook_done with no request outstanding, a packet of length 0, and a packet arriving while a hook request is outstanding are all ignored and produce no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| pkt_valid | input | 1 | Received packet strobe |
| pkt_len | input | IN_LW | Received packet length in bytes |
| pkt_data | input | IN_BYTES*8 | Received packet, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Reply strobe |
| rsp_len | output | OUT_LW | Reply length in bytes |
| rsp_data | output | OUT_BYTES*8 | Reply, byte 0 in bits 7:0 |
| shutdown_req | output | 1 | System power-off request pulse |
| reset_req | output | 1 | System restart request pulse |
| hook_req | output | 1 | External bus request pulse |
| hook_poll | output | 1 | Request is an auto-poll |
| hook_len | output | IN_LW | Forwarded byte count |
| hook_data | output | (IN_BYTES-1)*8 | Forwarded bytes, first in bits 7:0 |
| hook_done | input | 1 | External bus answer strobe |
| hook_status | input | 8 | Status byte from the external bus |
| hook_rlen | input | HOOK_LW | Returned byte count |
| hook_rdata | input | HOOK_BYTES*8 | Returned bytes, first in bits 7:0 |

## Verification
The assertions check properties that hold on every cycle. The seconds count either holds or steps by exactly one, depending on the tick and load. A reply and a hook request never coincide. Hook requests are single-cycle pulses, and a poll request forwards no bytes. Shutdown and restart pulses follow a reply and never appear together. The bench scenarios cover what depends on packet content: the byte layout of each reply, the big-endian time load, error codes, the poll period and the poll data framing, and packets or answers that are dropped because they arrive at the wrong moment.

// File: rtl/cmdrsp_pkg.sv
// Shared codes and types for the command packet responder.
// Assumes byte 0 of every buffer sits in bits 7:0.
package cmdrsp_pkg;
    // packet type codes (byte 0)
    localparam logic [7:0] PT_BUS = 8'h00;
    localparam logic [7:0] PT_DEV = 8'h01;
    localparam logic [7:0] PT_ERR = 8'h02;
    // device command codes (byte 1)
    localparam logic [7:0] CMD_AUTOPOLL  = 8'h01;
    localparam logic [7:0] CMD_GET_TIME  = 8'h03;
    localparam logic [7:0] CMD_SET_TIME  = 8'h09;
    localparam logic [7:0] CMD_POWER_OFF = 8'h0A;
    localparam logic [7:0] CMD_RESTART   = 8'h11;
    localparam logic [7:0] CMD_NOP_A     = 8'h13;
    localparam logic [7:0] CMD_NOP_B     = 8'h14;
    localparam logic [7:0] CMD_NOP_C     = 8'h19;
    localparam logic [7:0] CMD_NOP_D     = 8'h21;
    // reply bytes
    localparam logic [7:0] ST_OK     = 8'h00;
    localparam logic [7:0] POLL_MARK = 8'h40;
    localparam logic [7:0] ERR_SHORT = 8'hFF;
    // decoder looks at this many leading packet bytes
    localparam int DEC_BYTES = 6;
    localparam int SEC_W     = 32;

    typedef enum logic [1:0] {ACT_NONE, ACT_REPLY, ACT_BUS} act_e;
    typedef enum logic [1:0] {SYS_NONE, SYS_OFF, SYS_RESTART} sys_e;
    typedef enum logic [1:0] {ST_IDLE, ST_BUS_WAIT, ST_POLL_WAIT} state_e;
endpackage

// File: rtl/cmdrsp_rtc.sv
// Seconds counter for the real-time clock.
// Counts tick pulses modulo 2^SEC_W; a load takes priority over a tick.
module cmdrsp_rtc
    import cmdrsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    output logic [SEC_W-1:0] secs
);
    // hold, load or advance the seconds count
    always_ff @(posedge clk) begin
        if (!rst_n)     secs <= '0;
        else if (load)  secs <= load_val;
        else if (tick)  secs <= secs + SEC_W'(1);
    end
endmodule

// File: rtl/cmdrsp_poll_timer.sv
// Auto-poll period generator.
// Held at zero while disabled, so enabling always starts a fresh period;
// fires a one-cycle strobe every DIV cycles while enabled. Assumes DIV >= 2.
module cmdrsp_poll_timer #(
    parameter int DIV = 2_000_000,
    localparam int CW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic due
);
    logic [CW-1:0] cnt_q;

    assign due = en && (cnt_q == CW'(DIV - 1));

    // period counter, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (due)      cnt_q <= '0;
        else               cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/cmdrsp_decode.sv
// Combinational packet decoder.
// Looks at the first DEC_BYTES bytes and the length, and yields the
// action, the local reply and the side effects. Results are only
// meaningful while the top accepts a packet. Assumes OUT_BYTES >= 7.
module cmdrsp_decode
    import cmdrsp_pkg::*;
#(
    parameter int IN_LW     = 4,
    parameter int OUT_BYTES = 8,
    parameter int OUT_LW    = 4
) (
    input  logic [IN_LW-1:0]       pkt_len,
    input  logic [DEC_BYTES*8-1:0] pkt_head,
    input  logic [SEC_W-1:0]       secs,
    output act_e                   act,
    output logic [OUT_LW-1:0]      rep_len,
    output logic [OUT_BYTES*8-1:0] rep_data,
    output logic                   sec_load,
    output logic [SEC_W-1:0]       sec_val,
    output logic                   ap_write,
    output logic                   ap_val,
    output sys_e                   sys
);
    logic [7:0] b [DEC_BYTES];

    // split the packet head into bytes
    for (genvar i = 0; i < DEC_BYTES; i++) begin : g_split
        assign b[i] = pkt_head[i*8 +: 8];
    end

    assign sec_val = {b[2], b[3], b[4], b[5]};

    // command decode and reply assembly
    always_comb begin
        act      = ACT_NONE;
        rep_len  = '0;
        rep_data = '0;
        sec_load = 1'b0;
        ap_write = 1'b0;
        ap_val   = 1'b0;
        sys      = SYS_NONE;
        if (pkt_len != '0) begin
            act            = ACT_REPLY;
            rep_len        = OUT_LW'(2);
            rep_data[15:0] = {ST_OK, PT_DEV};
            if (b[0] == PT_BUS) begin
                act = ACT_BUS;
            end else if (b[0] != PT_DEV) begin
                rep_data[15:0] = {b[0], PT_ERR};
            end else if (pkt_len < IN_LW'(2)) begin
                rep_data[15:0] = {ERR_SHORT, PT_ERR};
            end else begin
                case (b[1])
                    CMD_AUTOPOLL: begin
                        ap_write = 1'b1;
                        ap_val   = (pkt_len >= IN_LW'(3)) && (b[2] != 8'h00);
                    end
                    CMD_GET_TIME: begin
                        rep_len        = OUT_LW'(7);
                        rep_data[55:0] = {secs[7:0], secs[15:8], secs[23:16],
                                          secs[31:24], CMD_GET_TIME, ST_OK, PT_DEV};
                    end
                    CMD_SET_TIME: begin
                        if (pkt_len >= IN_LW'(6)) sec_load = 1'b1;
                        else rep_data[15:0] = {CMD_SET_TIME, PT_ERR};
                    end
                    CMD_POWER_OFF: sys = SYS_OFF;
                    CMD_RESTART:   sys = SYS_RESTART;
                    CMD_NOP_A, CMD_NOP_B, CMD_NOP_C, CMD_NOP_D: ;
                    default: rep_data[15:0] = {b[1], PT_ERR};
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_responder.sv
// Peripheral command packet responder (top).
// Accepts one packet per strobe while idle, answers device and error
// packets one cycle later, forwards bus packets and auto-polls to an
// external hook and frames the answer. Packets arriving while a hook
// request is outstanding are dropped. Assumes IN_BYTES >= 6,
// HOOK_BYTES >= 5 and hook_rlen <= HOOK_BYTES.
module cmd_responder
    import cmdrsp_pkg::*;
#(
    parameter int  IN_BYTES   = 8,
    parameter int  HOOK_BYTES = 6,
    parameter int  POLL_DIV   = 2_000_000,
    localparam int IN_LW      = $clog2(IN_BYTES + 1),
    localparam int HOOK_LW    = $clog2(HOOK_BYTES + 1),
    localparam int OUT_BYTES  = HOOK_BYTES + 2,
    localparam int OUT_LW     = $clog2(OUT_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_1s,
    input  logic                      pkt_valid,
    input  logic [IN_LW-1:0]          pkt_len,
    input  logic [IN_BYTES*8-1:0]     pkt_data,
    output logic                      rsp_valid,
    output logic [OUT_LW-1:0]         rsp_len,
    output logic [OUT_BYTES*8-1:0]    rsp_data,
    output logic                      shutdown_req,
    output logic                      reset_req,
    output logic                      hook_req,
    output logic                      hook_poll,
    output logic [IN_LW-1:0]          hook_len,
    output logic [(IN_BYTES-1)*8-1:0] hook_data,
    input  logic                      hook_done,
    input  logic [7:0]                hook_status,
    input  logic [HOOK_LW-1:0]        hook_rlen,
    input  logic [HOOK_BYTES*8-1:0]   hook_rdata
);
    state_e                 state_q;
    sys_e                   sys_q;
    logic                   ap_on_q;
    logic                   poll_pend_q;
    logic                   poll_due;
    logic [SEC_W-1:0]       secs;
    logic                   sec_load;

    act_e                   dec_act;
    logic [OUT_LW-1:0]      dec_len;
    logic [OUT_BYTES*8-1:0] dec_data;
    logic                   dec_sec_load;
    logic [SEC_W-1:0]       dec_sec_val;
    logic                   dec_ap_write;
    logic                   dec_ap_val;
    sys_e                   dec_sys;

    logic take_pkt;
    logic issue_poll;

    assign take_pkt   = (state_q == ST_IDLE) && pkt_valid && (dec_act != ACT_NONE);
    assign issue_poll = (state_q == ST_IDLE) && poll_pend_q && ap_on_q && !take_pkt;
    assign sec_load   = take_pkt && dec_sec_load;

    cmdrsp_decode #(
        .IN_LW     (IN_LW),
        .OUT_BYTES (OUT_BYTES),
        .OUT_LW    (OUT_LW)
    ) u_decode (
        .pkt_len  (pkt_len),
        .pkt_head (pkt_data[DEC_BYTES*8-1:0]),
        .secs     (secs),
        .act      (dec_act),
        .rep_len  (dec_len),
        .rep_data (dec_data),
        .sec_load (dec_sec_load),
        .sec_val  (dec_sec_val),
        .ap_write (dec_ap_write),
        .ap_val   (dec_ap_val),
        .sys      (dec_sys)
    );

    cmdrsp_rtc u_rtc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1s),
        .load     (sec_load),
        .load_val (dec_sec_val),
        .secs     (secs)
    );

    cmdrsp_poll_timer #(
        .DIV (POLL_DIV)
    ) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ap_on_q),
        .due   (poll_due)
    );

    // auto-poll enable, written by the auto-poll command
    always_ff @(posedge clk) begin
        if (!rst_n)                          ap_on_q <= 1'b0;
        else if (take_pkt && dec_ap_write)   ap_on_q <= dec_ap_val;
    end

    // remembers a poll period that expired until the hook is free
    always_ff @(posedge clk) begin
        if (!rst_n || !ap_on_q) poll_pend_q <= 1'b0;
        else if (poll_due)      poll_pend_q <= 1'b1;
        else if (issue_poll)    poll_pend_q <= 1'b0;
    end

    // main sequencer: replies, hook requests and system pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            sys_q        <= SYS_NONE;
            rsp_valid    <= 1'b0;
            rsp_len      <= '0;
            rsp_data     <= '0;
            shutdown_req <= 1'b0;
            reset_req    <= 1'b0;
            hook_req     <= 1'b0;
            hook_poll    <= 1'b0;
            hook_len     <= '0;
            hook_data    <= '0;
        end else begin
            rsp_valid    <= 1'b0;
            hook_req     <= 1'b0;
            shutdown_req <= (sys_q == SYS_OFF);
            reset_req    <= (sys_q == SYS_RESTART);
            sys_q        <= SYS_NONE;
            case (state_q)
                ST_IDLE: begin
                    if (take_pkt) begin
                        if (dec_act == ACT_BUS) begin
                            hook_req  <= 1'b1;
                            hook_poll <= 1'b0;
                            hook_len  <= pkt_len - IN_LW'(1);
                            hook_data <= pkt_data[IN_BYTES*8-1:8];
                            state_q   <= ST_BUS_WAIT;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_len   <= dec_len;
                            rsp_data  <= dec_data;
                            sys_q     <= dec_sys;
                        end
                    end else if (issue_poll) begin
                        hook_req  <= 1'b1;
                        hook_poll <= 1'b1;
                        hook_len  <= '0;
                        state_q   <= ST_POLL_WAIT;
                    end
                end
                ST_BUS_WAIT: begin
                    if (hook_done) begin
                        rsp_valid <= 1'b1;
                        rsp_len   <= OUT_LW'(hook_rlen) + OUT_LW'(2);
                        rsp_data  <= {hook_rdata, hook_status, PT_BUS};
                        state_q   <= ST_IDLE;
                    end
                end
                ST_POLL_WAIT: begin
                    if (hook_done) begin
                        if (hook_rlen != '0) begin
                            rsp_valid <= 1'b1;
                            rsp_len   <= OUT_LW'(hook_rlen) + OUT_LW'(2);
                            rsp_data  <= {hook_rdata, POLL_MARK, PT_BUS};
                        end
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_responder_chk.sv
// Property checker for cmd_responder, attached by bind.
module cmd_responder_chk #(
    parameter int IN_LW     = 4,
    parameter int OUT_BYTES = 8,
    parameter int OUT_LW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1s,
    input logic              rsp_valid,
    input logic [OUT_LW-1:0] rsp_len,
    input logic              shutdown_req,
    input logic              reset_req,
    input logic              hook_req,
    input logic              hook_poll,
    input logic [IN_LW-1:0]  hook_len,
    input logic [31:0]       secs,
    input logic              sec_load
);
    // R7
    reply_hook_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !hook_req);
    // R7
    reply_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_len >= OUT_LW'(2) && rsp_len <= OUT_LW'(OUT_BYTES)));
    // R6
    off_after_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(rsp_valid));
    // R6
    restart_after_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(rsp_valid));
    // R6
    sysreq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_req && reset_req));
    // R8
    hook_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hook_req |=> !hook_req);
    // R9
    poll_no_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hook_req && hook_poll) |-> (hook_len == '0));
    // R4
    secs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1s && !sec_load) |=> $stable(secs));
    // R4
    secs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1s && !sec_load) |=> (secs == $past(secs) + 32'd1));
endmodule

bind cmd_responder cmd_responder_chk #(
    .IN_LW     (IN_LW),
    .OUT_BYTES (OUT_BYTES),
    .OUT_LW    (OUT_LW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_1s      (tick_1s),
    .rsp_valid    (rsp_valid),
    .rsp_len      (rsp_len),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .hook_req     (hook_req),
    .hook_poll    (hook_poll),
    .hook_len     (hook_len),
    .secs         (secs),
    .sec_load     (sec_load)
);

// File: tb/cmd_responder_tb_top.sv
// Scoreboard bench: tasks queue expected replies, a monitor compares them.
module cmd_responder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int POLL_DIV   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1s = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [3:0]  pkt_len = '0;
    logic [63:0] pkt_data = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_len;
    logic [63:0] rsp_data;
    logic        shutdown_req, reset_req;
    logic        hook_req, hook_poll;
    logic [3:0]  hook_len;
    logic [55:0] hook_data;
    logic        hook_done = 1'b0;
    logic [7:0]  hook_status = '0;
    logic [2:0]  hook_rlen = '0;
    logic [47:0] hook_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int hook_cnt = 0;
    logic        last_poll;
    logic [3:0]  last_len;
    logic [55:0] last_data;

    int          exp_len_q[$];
    logic [63:0] exp_dat_q[$];
    string       exp_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_responder #(.IN_BYTES(8), .HOOK_BYTES(6), .POLL_DIV(POLL_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_data(pkt_data),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .shutdown_req(shutdown_req), .reset_req(reset_req),
        .hook_req(hook_req), .hook_poll(hook_poll), .hook_len(hook_len),
        .hook_data(hook_data), .hook_done(hook_done), .hook_status(hook_status),
        .hook_rlen(hook_rlen), .hook_rdata(hook_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_rsp(input string tag, input int len, input logic [63:0] dat);
        exp_tag_q.push_back(tag);
        exp_len_q.push_back(len);
        exp_dat_q.push_back(dat);
    endtask

    // monitor: replies against the scoreboard, hook requests captured
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_len_q.size() == 0) begin
                check(1'b0, "R11", "unexpected reply", rsp_data, 64'h0);
            end else begin
                automatic string       t = exp_tag_q.pop_front();
                automatic int          l = exp_len_q.pop_front();
                automatic logic [63:0] d = exp_dat_q.pop_front();
                automatic logic [63:0] m = (l >= 8) ? '1 : ((64'h1 << (l*8)) - 64'h1);
                check(rsp_len == 4'(l), t, "reply length", 64'(rsp_len), 64'(l));
                check((rsp_data & m) == (d & m), t, "reply bytes", rsp_data & m, d & m);
            end
        end
        if (rst_n && hook_req) begin
            hook_cnt++;
            last_poll = hook_poll;
            last_len  = hook_len;
            last_data = hook_data;
        end
    end

    // one packet, then the system request lines one cycle after the reply
    task automatic send(input int len, input logic [63:0] d, input bit sd,
                        input bit rs, input bit tk, input string tag);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = 4'(len); pkt_data = d; tick_1s = tk;
        @(negedge clk);
        pkt_valid = 1'b0; tick_1s = 1'b0;
        @(negedge clk);
        check(shutdown_req == sd, tag, "shutdown_req", 64'(shutdown_req), 64'(sd));
        check(reset_req == rs, tag, "reset_req", 64'(reset_req), 64'(rs));
    endtask

    task automatic answer(input logic [7:0] st, input int n, input logic [47:0] d);
        @(negedge clk);
        hook_done = 1'b1; hook_status = st; hook_rlen = 3'(n); hook_rdata = d;
        @(negedge clk);
        hook_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic get_time(input logic [31:0] s, input string tag);
        expect_rsp(tag, 7, {8'h0, s[7:0], s[15:8], s[23:16], s[31:24], 8'h03, 8'h00, 8'h01});
        send(2, {8'h03, 8'h01}, 0, 0, 0, tag);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 64'h0, 64'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int h0;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!rsp_valid && !hook_req, "R1", "reply/hook idle", {rsp_valid, hook_req}, 0);
        check(!shutdown_req && !reset_req, "R1", "sys idle", {shutdown_req, reset_req}, 0);
        get_time(32'h0, "R1");
        repeat (2 * POLL_DIV) @(negedge clk);
        check(hook_cnt == 0, "R1", "no poll after reset", 64'(hook_cnt), 0);

        // R4 ticking, load, load beating tick, wrap
        repeat (3) pulse_tick();
        get_time(32'd3, "R4");
        expect_rsp("R4", 2, 64'h0001);
        send(6, {8'h78, 8'h56, 8'h34, 8'h12, 8'h09, 8'h01}, 0, 0, 1, "R4");
        get_time(32'h12345678, "R4");
        pulse_tick();
        get_time(32'h12345679, "R4");
        expect_rsp("R4", 2, 64'h0902);
        send(3, {8'h12, 8'h09, 8'h01}, 0, 0, 0, "R4");
        get_time(32'h12345679, "R4");
        expect_rsp("R4", 2, 64'h0001);
        send(6, {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h09, 8'h01}, 0, 0, 0, "R4");
        pulse_tick();
        get_time(32'h0, "R3");

        // R5 no-op commands
        expect_rsp("R5", 2, 64'h0001); send(2, {8'h13, 8'h01}, 0, 0, 0, "R5");
        expect_rsp("R5", 2, 64'h0001); send(2, {8'h14, 8'h01}, 0, 0, 0, "R5");
        expect_rsp("R5", 2, 64'h0001); send(2, {8'h19, 8'h01}, 0, 0, 0, "R5");
        expect_rsp("R5", 2, 64'h0001); send(2, {8'h21, 8'h01}, 0, 0, 0, "R5");

        // R2 errors, R11 empty packet
        expect_rsp("R2", 2, 64'h0702); send(1, 64'h07, 0, 0, 0, "R2");
        expect_rsp("R2", 2, 64'hFF02); send(1, 64'h01, 0, 0, 0, "R2");
        expect_rsp("R2", 2, 64'h5502); send(2, {8'h55, 8'h01}, 0, 0, 0, "R2");
        send(0, 64'h0301, 0, 0, 0, "R11");

        // R6 system requests after the reply
        expect_rsp("R6", 2, 64'h0001); send(2, {8'h0A, 8'h01}, 1, 0, 0, "R6");
        expect_rsp("R6", 2, 64'h0001); send(2, {8'h11, 8'h01}, 0, 1, 0, "R6");

        // R8 bus forwarding; R11 packet during wait and stray answer dropped
        h0 = hook_cnt;
        send(3, {8'hB2, 8'hA1, 8'h00}, 0, 0, 0, "R8");
        check(hook_cnt == h0 + 1, "R8", "hook request count", 64'(hook_cnt), 64'(h0 + 1));
        check(last_poll == 1'b0 && last_len == 4'd2, "R8", "hook kind/len",
              {last_poll, last_len}, {1'b0, 4'd2});
        check(last_data[15:0] == 16'hB2A1, "R8", "hook bytes", 64'(last_data[15:0]), 64'hB2A1);
        send(2, {8'h03, 8'h01}, 0, 0, 0, "R11");
        expect_rsp("R8", 5, {24'h0, 8'hE5, 8'hD4, 8'hC3, 8'h05, 8'h00});
        answer(8'h05, 3, {24'h0, 8'hE5, 8'hD4, 8'hC3});
        answer(8'h07, 2, 48'h1234);

        // R9 auto-poll period and R10 framing
        h0 = hook_cnt;
        expect_rsp("R9", 2, 64'h0001);
        send(3, {8'h01, 8'h01, 8'h01}, 0, 0, 0, "R9");
        n = 0;
        while (hook_cnt == h0 && n < POLL_DIV + 10) begin @(negedge clk); n++; end
        check(n >= POLL_DIV - 3 && n <= POLL_DIV + 3, "R9", "poll delay", 64'(n), 64'(POLL_DIV));
        check(last_poll == 1'b1 && last_len == 4'd0, "R9", "poll kind/len",
              {last_poll, last_len}, {1'b1, 4'd0});
        expect_rsp("R10", 4, {32'h0, 8'h22, 8'h11, 8'h40, 8'h00});
        answer(8'h00, 2, {32'h0, 8'h22, 8'h11});
        h0 = hook_cnt;
        n = 0;
        while (hook_cnt == h0 && n < POLL_DIV + 10) begin @(negedge clk); n++; end
        check(hook_cnt == h0 + 1, "R9", "second poll", 64'(hook_cnt), 64'(h0 + 1));
        answer(8'h00, 0, 48'h0);
        expect_rsp("R9", 2, 64'h0001);
        send(2, {8'h01, 8'h01}, 0, 0, 0, "R9");
        h0 = hook_cnt;
        repeat (3 * POLL_DIV) @(negedge clk);
        check(hook_cnt == h0, "R9", "poll stopped", 64'(hook_cnt), 64'(h0));

        repeat (4) @(negedge clk);
        check(exp_len_q.size() == 0, "R7", "replies outstanding", 64'(exp_len_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule